// File: doc/BRIEF.md
# Paged Descriptor Ring Index Manager

This block keeps the bookkeeping for three circular descriptor rings held in host memory: a request ring that the host fills and the device drains, a completion ring that the device fills, and a message ring that the device fills for asynchronous events. Each ring's storage is spread over several pages that need not be contiguous. The block holds a page-frame table and a size for each ring. It turns free-running 32-bit ring indices into descriptor byte addresses. It decides whether a request descriptor is pending and whether the message ring has space. It also produces the writes that publish producer and consumer indices into the shared ring-state area.

Software first loads the page-frame tables through a table-write port. A data-ring setup strobe then fixes the request and completion ring sizes, and an optional message-ring setup strobe follows. After that, the consuming logic issues pop strobes to get descriptor addresses and flush strobes to publish progress. Reading and writing the descriptor contents is left to the surrounding logic. The state-write port carries only a field code and a 32-bit value.

Top module: `ring_index_mgr`

## Requirements
- R1: An active-low reset clears every page-table entry, ring size, internal pointer and pending state write, and drops both ready flags. After reset, a pop returns address 0 and no state write is issued.
- R2: A data setup is accepted only when the request page count and the completion page count both lie in 1..MAX_PAGES. A message setup is accepted only when the data rings are ready and its page count lies in 1..MSG_MAX_PAGES. setup_done pulses on the clock after the strobe and setup_err is high with it on a refusal. A refused setup changes nothing else.
- R3: An accepted data setup zeroes the request-consumed and completion-filled pointers and sets data_ready. It then emits six state writes in this order: field 0 (request producer) = 0, field 1 (request consumer) = 0, field 2 (request log2) = L, field 3 (completion producer) = 0, field 4 (completion consumer) = 0, field 5 (completion log2) = L. Here L is the bit length of (pages × entries per page − 1).
- R4: A request pop returns a descriptor address only when data_ready is set, req_prod differs from the consumed pointer, and (req_prod − consumed) modulo 2^32 is below MAX_PAGES × REQ_EPP. Otherwise it returns address 0 and leaves the pointer unchanged.
- R5: The descriptor address for index p on a ring with mask M is (ppn[(p & M) / EPP] << PAGE_SHIFT) + ((p & M) % EPP) × descriptor size. The mask M is 2^L − 1.
- R6: Each successful request pop advances the consumed pointer by one. The pointer runs free over 32 bits, and the mask alone folds it back onto the ring.
- R7: flush_req emits one state write to field 1 carrying the current consumed pointer.
- R8: Once data_ready is set, a completion pop always returns an address and advances the filled pointer; there is no overflow check. The filled pointer appears on the state port only after flush_cmp, as a write to field 3.
- R9: An accepted message setup zeroes the message pointer, sets msg_ready and emits field 6 (message producer) = 0, field 7 (message consumer) = 0 and field 8 (message log2) = L.
- R10: msg_room is high exactly when msg_ready is set and (msg_prod − msg_cons) modulo 2^32 < M + 1. A message pop without room returns 0 and does not advance the pointer. flush_msg emits field 6 with the filled message pointer.
- R11: The state port issues at most one write per clock. When several writes are pending, the lowest field code goes first, and every pending write is issued in the end.
- R12: A pop response (rsp_valid with rsp_addr) appears on the clock after the pop strobe. When strobes coincide, the request pop takes precedence over the completion pop, and the completion pop over the message pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pt_we | input | 1 | Page-table write strobe |
| pt_ring | input | 2 | Table select: 0 request, 1 completion, 2 message |
| pt_idx | input | IDX_W | Page slot within the table |
| pt_ppn | input | PPN_W | Page frame number |
| setup_data | input | 1 | Data-ring setup strobe |
| setup_msg | input | 1 | Message-ring setup strobe |
| setup_req_pages | input | CNT_W | Request ring page count |
| setup_cmp_pages | input | CNT_W | Completion ring page count |
| setup_msg_pages | input | CNT_W | Message ring page count |
| setup_done | output | 1 | Setup handled (one-clock pulse) |
| setup_err | output | 1 | Setup refused, valid with setup_done |
| data_ready | output | 1 | Request and completion rings configured |
| msg_ready | output | 1 | Message ring configured |
| req_prod | input | 32 | Request producer index from shared state |
| msg_prod | input | 32 | Message producer index from shared state |
| msg_cons | input | 32 | Message consumer index from shared state |
| msg_room | output | 1 | Message ring has a free slot |
| pop_req | input | 1 | Pop a request descriptor |
| pop_cmp | input | 1 | Pop a completion slot |
| pop_msg | input | 1 | Pop a message slot |
| rsp_valid | output | 1 | Pop response valid |
| rsp_addr | output | ADDR_W | Descriptor byte address, 0 if none |
| flush_req | input | 1 | Publish the request consumer index |
| flush_cmp | input | 1 | Publish the completion producer index |
| flush_msg | input | 1 | Publish the message producer index |
| sw_valid | output | 1 | State write valid |
| sw_field | output | 4 | State field code |
| sw_data | output | 32 | State field value |

## Verification
The bench drains the request ring across a page boundary and past the point where the mask folds the index back to zero. A design that split the index with the wrong shift would land on the wrong page, and one that skipped the mask would run off the table. It places the producer exactly one ring's span ahead of the consumer and also one step behind it. A design that compared only for inequality would hand out stale descriptors there. It pops the completion ring beyond its size, checks that nothing is published before the flush, and fills the message ring to capacity so that a missing room check would overwrite unread entries. Coinciding flushes, refused setups, and a reset that must wipe the page tables complete the set.

// File: rtl/ring_index_mgr.sv
module ring_index_mgr #(
  parameter int PPN_W         = 20,
  parameter int PAGE_SHIFT    = 12,
  parameter int MAX_PAGES     = 4,
  parameter int MSG_MAX_PAGES = 2,
  parameter int REQ_EPP       = 32,
  parameter int REQ_DESC      = 128,
  parameter int CMP_EPP       = 128,
  parameter int CMP_DESC      = 32,
  parameter int MSG_EPP       = 32,
  parameter int MSG_DESC      = 128,
  parameter int CNT_W         = 4,
  localparam int IDX_W        = $clog2(MAX_PAGES),
  localparam int ADDR_W       = PPN_W + PAGE_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pt_we,
  input  logic [1:0]        pt_ring,
  input  logic [IDX_W-1:0]  pt_idx,
  input  logic [PPN_W-1:0]  pt_ppn,
  input  logic              setup_data,
  input  logic              setup_msg,
  input  logic [CNT_W-1:0]  setup_req_pages,
  input  logic [CNT_W-1:0]  setup_cmp_pages,
  input  logic [CNT_W-1:0]  setup_msg_pages,
  output logic              setup_done,
  output logic              setup_err,
  output logic              data_ready,
  output logic              msg_ready,
  input  logic [31:0]       req_prod,
  input  logic [31:0]       msg_prod,
  input  logic [31:0]       msg_cons,
  output logic              msg_room,
  input  logic              pop_req,
  input  logic              pop_cmp,
  input  logic              pop_msg,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_addr,
  input  logic              flush_req,
  input  logic              flush_cmp,
  input  logic              flush_msg,
  output logic              sw_valid,
  output logic [3:0]        sw_field,
  output logic [31:0]       sw_data
);

  localparam int MIDX_W    = (MSG_MAX_PAGES > 1) ? $clog2(MSG_MAX_PAGES) : 1;
  localparam int REQ_SH    = $clog2(REQ_EPP);
  localparam int CMP_SH    = $clog2(CMP_EPP);
  localparam int MSG_SH    = $clog2(MSG_EPP);
  localparam int REQ_DSH   = $clog2(REQ_DESC);
  localparam int CMP_DSH   = $clog2(CMP_DESC);
  localparam int MSG_DSH   = $clog2(MSG_DESC);
  localparam int REQ_LIMIT = MAX_PAGES * REQ_EPP;
  localparam int NFIELD    = 9;

  logic [PPN_W-1:0] req_tab [MAX_PAGES];
  logic [PPN_W-1:0] cmp_tab [MAX_PAGES];
  logic [PPN_W-1:0] msg_tab [MSG_MAX_PAGES];

  logic [5:0]  req_lg, cmp_lg, msg_lg;
  logic [31:0] req_ptr, cmp_ptr, msg_ptr;
  logic [31:0] req_mask, cmp_mask, msg_mask;
  logic [NFIELD-1:0] pend, pend_set, pend_sel;
  logic [3:0]  nxt_field;
  logic [31:0] nxt_data;

  function automatic logic [5:0] bitlen(input logic [31:0] v);
    logic [5:0] r;
    r = '0;
    for (int i = 0; i < 32; i++)
      if (v[i]) r = 6'(i + 1);
    return r;
  endfunction

  assign req_mask = (32'd1 << req_lg) - 32'd1;
  assign cmp_mask = (32'd1 << cmp_lg) - 32'd1;
  assign msg_mask = (32'd1 << msg_lg) - 32'd1;

  logic [31:0] req_i, cmp_i, msg_i;
  assign req_i = req_ptr & req_mask;
  assign cmp_i = cmp_ptr & cmp_mask;
  assign msg_i = msg_ptr & msg_mask;

  logic [IDX_W-1:0]  req_pg, cmp_pg;
  logic [MIDX_W-1:0] msg_pg;
  assign req_pg = IDX_W'(req_i >> REQ_SH);
  assign cmp_pg = IDX_W'(cmp_i >> CMP_SH);
  assign msg_pg = MIDX_W'(msg_i >> MSG_SH);

  logic [ADDR_W-1:0] req_addr, cmp_addr, msg_addr;
  assign req_addr = {req_tab[req_pg], {PAGE_SHIFT{1'b0}}}
                  + (ADDR_W'(req_i & 32'(REQ_EPP - 1)) << REQ_DSH);
  assign cmp_addr = {cmp_tab[cmp_pg], {PAGE_SHIFT{1'b0}}}
                  + (ADDR_W'(cmp_i & 32'(CMP_EPP - 1)) << CMP_DSH);
  assign msg_addr = {msg_tab[msg_pg], {PAGE_SHIFT{1'b0}}}
                  + (ADDR_W'(msg_i & 32'(MSG_EPP - 1)) << MSG_DSH);

  logic [31:0] req_gap;
  logic        req_avail;
  assign req_gap   = req_prod - req_ptr;
  assign req_avail = data_ready && (req_gap != 32'd0) && (req_gap < 32'(REQ_LIMIT));
  assign msg_room  = msg_ready && ((msg_prod - msg_cons) < (msg_mask + 32'd1));

  logic data_ok, msg_ok, data_acc, msg_acc;
  assign data_ok  = (setup_req_pages != '0) && (32'(setup_req_pages) <= 32'(MAX_PAGES))
                 && (setup_cmp_pages != '0) && (32'(setup_cmp_pages) <= 32'(MAX_PAGES));
  assign msg_ok   = data_ready && (setup_msg_pages != '0)
                 && (32'(setup_msg_pages) <= 32'(MSG_MAX_PAGES));
  assign data_acc = setup_data && data_ok;
  assign msg_acc  = setup_msg && !setup_data && msg_ok;

  assign pend_set = (data_acc ? 9'h03F : 9'h000) | (msg_acc ? 9'h1C0 : 9'h000)
                  | (flush_req ? 9'h002 : 9'h000) | (flush_cmp ? 9'h008 : 9'h000)
                  | (flush_msg ? 9'h040 : 9'h000);

  always_comb begin
    nxt_field = '0;
    for (int i = NFIELD - 1; i >= 0; i--)
      if (pend[i]) nxt_field = 4'(i);
    pend_sel = (pend != '0) ? (9'd1 << nxt_field) : '0;
    case (nxt_field)
      4'd1:    nxt_data = req_ptr;
      4'd2:    nxt_data = 32'(req_lg);
      4'd3:    nxt_data = cmp_ptr;
      4'd5:    nxt_data = 32'(cmp_lg);
      4'd6:    nxt_data = msg_ptr;
      4'd8:    nxt_data = 32'(msg_lg);
      default: nxt_data = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MAX_PAGES; i++) begin
        req_tab[i] <= '0;
        cmp_tab[i] <= '0;
      end
      for (int i = 0; i < MSG_MAX_PAGES; i++) msg_tab[i] <= '0;
      req_lg <= '0; cmp_lg <= '0; msg_lg <= '0;
      req_ptr <= '0; cmp_ptr <= '0; msg_ptr <= '0;
      data_ready <= 1'b0; msg_ready <= 1'b0;
      setup_done <= 1'b0; setup_err <= 1'b0;
      rsp_valid <= 1'b0; rsp_addr <= '0;
      pend <= '0;
      sw_valid <= 1'b0; sw_field <= '0; sw_data <= '0;
    end else begin
      if (pt_we) begin
        case (pt_ring)
          2'd0: req_tab[pt_idx] <= pt_ppn;
          2'd1: cmp_tab[pt_idx] <= pt_ppn;
          2'd2: if (32'(pt_idx) < 32'(MSG_MAX_PAGES)) msg_tab[MIDX_W'(pt_idx)] <= pt_ppn;
          default: ;
        endcase
      end

      rsp_valid <= pop_req || pop_cmp || pop_msg;
      if (pop_req) begin
        rsp_addr <= req_avail ? req_addr : '0;
        if (req_avail) req_ptr <= req_ptr + 32'd1;
      end else if (pop_cmp) begin
        rsp_addr <= data_ready ? cmp_addr : '0;
        if (data_ready) cmp_ptr <= cmp_ptr + 32'd1;
      end else if (pop_msg) begin
        rsp_addr <= msg_room ? msg_addr : '0;
        if (msg_room) msg_ptr <= msg_ptr + 32'd1;
      end

      setup_done <= setup_data || setup_msg;
      setup_err  <= (setup_data && !data_ok) || (setup_msg && !setup_data && !msg_ok);
      if (data_acc) begin
        req_lg     <= bitlen(32'(setup_req_pages) * 32'(REQ_EPP) - 32'd1);
        cmp_lg     <= bitlen(32'(setup_cmp_pages) * 32'(CMP_EPP) - 32'd1);
        req_ptr    <= '0;
        cmp_ptr    <= '0;
        data_ready <= 1'b1;
      end
      if (msg_acc) begin
        msg_lg    <= bitlen(32'(setup_msg_pages) * 32'(MSG_EPP) - 32'd1);
        msg_ptr   <= '0;
        msg_ready <= 1'b1;
      end

      pend     <= (pend & ~pend_sel) | pend_set;
      sw_valid <= (pend != '0);
      sw_field <= nxt_field;
      sw_data  <= nxt_data;
    end
  end

  // R4
  req_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && req_prod == req_ptr) |=> (rsp_valid && rsp_addr == '0));

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pop_req && !setup_data) |=> $stable(req_ptr));

  // R8
  cmp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_cmp && !pop_req && data_ready && !setup_data) |=> (cmp_ptr == $past(cmp_ptr) + 32'd1));

  // R10
  msg_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_msg && !msg_room && !setup_msg) |=> $stable(msg_ptr));

  // R11
  sw_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_valid |-> (sw_field < 4'(NFIELD)));

  // R2
  setup_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    setup_done |-> $past(setup_data || setup_msg));

endmodule

// File: tb/tb_ring_index_mgr.sv
module tb_ring_index_mgr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pt_we = 0;
  logic [1:0]  pt_ring = 0;
  logic [1:0]  pt_idx = 0;
  logic [19:0] pt_ppn = 0;
  logic        setup_data = 0, setup_msg = 0;
  logic [3:0]  setup_req_pages = 0, setup_cmp_pages = 0, setup_msg_pages = 0;
  logic        setup_done, setup_err, data_ready, msg_ready, msg_room;
  logic [31:0] req_prod = 0, msg_prod = 0, msg_cons = 0;
  logic        pop_req = 0, pop_cmp = 0, pop_msg = 0;
  logic        rsp_valid;
  logic [31:0] rsp_addr;
  logic        flush_req = 0, flush_cmp = 0, flush_msg = 0;
  logic        sw_valid;
  logic [3:0]  sw_field;
  logic [31:0] sw_data;

  int checks = 0, errors = 0, lc = 0;
  logic [3:0]  lf [16];
  logic [31:0] ld [16];
  bit done = 0;

  always #10 clk = ~clk;

  ring_index_mgr dut (
    .clk(clk), .rst_n(rst_n), .pt_we(pt_we), .pt_ring(pt_ring), .pt_idx(pt_idx),
    .pt_ppn(pt_ppn), .setup_data(setup_data), .setup_msg(setup_msg),
    .setup_req_pages(setup_req_pages), .setup_cmp_pages(setup_cmp_pages),
    .setup_msg_pages(setup_msg_pages), .setup_done(setup_done), .setup_err(setup_err),
    .data_ready(data_ready), .msg_ready(msg_ready), .req_prod(req_prod),
    .msg_prod(msg_prod), .msg_cons(msg_cons), .msg_room(msg_room), .pop_req(pop_req),
    .pop_cmp(pop_cmp), .pop_msg(pop_msg), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
    .flush_req(flush_req), .flush_cmp(flush_cmp), .flush_msg(flush_msg),
    .sw_valid(sw_valid), .sw_field(sw_field), .sw_data(sw_data));

  always @(negedge clk)
    if (rst_n && sw_valid && lc < 16) begin
      lf[lc] = sw_field;
      ld[lc] = sw_data;
      lc++;
    end

  task automatic check(input string r, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic step(); @(posedge clk); #5; endtask
  task automatic idle(input int n); for (int i = 0; i < n; i++) step(); endtask

  function automatic logic [31:0] ea_req(input int p);
    int i = p & 63;
    return ((i >> 5) == 0 ? 32'h11111000 : 32'h22222000) + 32'(i & 31) * 128;
  endfunction
  function automatic logic [31:0] ea_cmp(input int p);
    return 32'h33333000 + 32'(p & 127) * 32;
  endfunction

  task automatic pop(input int kind, input logic [31:0] exp, input string r);
    pop_req = (kind == 0); pop_cmp = (kind == 1); pop_msg = (kind == 2);
    step();
    pop_req = 0; pop_cmp = 0; pop_msg = 0;
    check({r, " rsp_valid"}, rsp_valid, 1);
    check({r, " rsp_addr"}, rsp_addr, exp);
  endtask

  task automatic wr_pt(input logic [1:0] rg, input logic [1:0] ix, input logic [19:0] p);
    pt_we = 1; pt_ring = rg; pt_idx = ix; pt_ppn = p;
    step();
    pt_we = 0;
  endtask

  task automatic do_setup(input bit msg, input int a, input int b, input bit exp_err, input string r);
    setup_data = !msg; setup_msg = msg;
    setup_req_pages = 4'(a); setup_cmp_pages = 4'(b); setup_msg_pages = 4'(a);
    step();
    setup_data = 0; setup_msg = 0;
    check({r, " setup_done"}, setup_done, 1);
    check({r, " setup_err"}, setup_err, exp_err);
  endtask

  task automatic t_reset();
    check("R1 data_ready", data_ready, 0);
    check("R1 msg_ready", msg_ready, 0);
    check("R1 sw_valid", sw_valid, 0);
    check("R1 rsp_valid", rsp_valid, 0);
    check("R1 msg_room", msg_room, 0);
    req_prod = 5;
    pop(0, 0, "R1 pop before setup");
  endtask

  task automatic t_bad_setup();
    do_setup(0, 0, 1, 1, "R2 zero req pages");
    do_setup(0, 1, 5, 1, "R2 too many cmp pages");
    check("R2 not ready after refusal", data_ready, 0);
    do_setup(1, 1, 0, 1, "R2 msg before data");
    idle(3);
    check("R2 no writes after refusal", lc, 0);
  endtask

  task automatic t_setup();
    wr_pt(0, 0, 20'h11111); wr_pt(0, 1, 20'h22222);
    wr_pt(1, 0, 20'h33333); wr_pt(2, 0, 20'h44444);
    lc = 0;
    do_setup(0, 2, 1, 0, "R2 data setup");
    check("R3 data_ready", data_ready, 1);
    idle(8);
    check("R3 write count", lc, 6);
    for (int i = 0; i < 6; i++) check("R3 field order", lf[i], i);
    check("R3 req log2", ld[2], 6);
    check("R3 cmp log2", ld[5], 7);
    check("R3 zero indices", ld[0] | ld[1] | ld[3] | ld[4], 0);
  endtask

  task automatic t_req_pops();
    req_prod = 3;
    for (int p = 0; p < 3; p++) pop(0, ea_req(p), "R5 req addr");
    pop(0, 0, "R4 req empty");
    lc = 0; flush_req = 1; step(); flush_req = 0; idle(3);
    check("R7 flush count", lc, 1);
    check("R7 flush field", lf[0], 1);
    check("R7 flush value", ld[0], 3);
  endtask

  task automatic t_req_wrap();
    req_prod = 70;
    for (int p = 3; p < 70; p++) pop(0, ea_req(p), "R6 req wrap addr");
    req_prod = 70 + 128;
    pop(0, 0, "R4 gap equals ring span");
    req_prod = 69;
    pop(0, 0, "R4 producer behind");
    req_prod = 70 + 127;
    pop(0, ea_req(70), "R4 gap just below span");
    lc = 0; flush_req = 1; step(); flush_req = 0; idle(3);
    check("R7 flush after wrap", ld[0], 71);
  endtask

  task automatic t_cmp();
    lc = 0;
    for (int p = 0; p < 130; p++) pop(1, ea_cmp(p), "R8 cmp addr");
    idle(2);
    check("R8 no publish before flush", lc, 0);
    flush_cmp = 1; step(); flush_cmp = 0; idle(3);
    check("R8 flush field", lf[0], 3);
    check("R8 flush value", ld[0], 130);
  endtask

  task automatic t_msg_setup();
    do_setup(1, 0, 0, 1, "R2 msg zero pages");
    do_setup(1, 3, 0, 1, "R2 msg too many pages");
    check("R9 not ready", msg_ready, 0);
    lc = 0;
    do_setup(1, 1, 0, 0, "R9 msg setup");
    idle(5);
    check("R9 write count", lc, 3);
    check("R9 field 6", lf[0], 6);
    check("R9 field 7", lf[1], 7);
    check("R9 field 8", lf[2], 8);
    check("R9 log2", ld[2], 5);
    check("R9 zeros", ld[0] | ld[1], 0);
  endtask

  task automatic t_msg_room();
    msg_prod = 32; msg_cons = 0; #1;
    check("R10 full ring no room", msg_room, 0);
    pop(2, 0, "R10 pop without room");
    msg_prod = 31; #1;
    check("R10 room", msg_room, 1);
    pop(2, 32'h44444000, "R10 pointer held then pop");
    pop(2, 32'h44444080, "R10 second pop");
    lc = 0; flush_msg = 1; step(); flush_msg = 0; idle(3);
    check("R10 flush field", lf[0], 6);
    check("R10 flush value", ld[0], 2);
  endtask

  task automatic t_flush_all();
    lc = 0;
    flush_msg = 1; flush_cmp = 1; flush_req = 1; step();
    flush_msg = 0; flush_cmp = 0; flush_req = 0; idle(5);
    check("R11 count", lc, 3);
    check("R11 first", lf[0], 1);
    check("R11 second", lf[1], 3);
    check("R11 third", lf[2], 6);
    check("R11 values", {ld[0], ld[1]}, {32'd71, 32'd130});
  endtask

  task automatic t_pop_priority();
    req_prod = 72;
    pop_req = 1; pop_cmp = 1; step(); pop_req = 0; pop_cmp = 0;
    check("R12 req wins", rsp_addr, ea_req(71));
    pop(1, ea_cmp(130), "R12 cmp pointer untouched");
  endtask

  task automatic t_reset_mid();
    rst_n = 0; idle(2); rst_n = 1; step();
    check("R1 data_ready cleared", data_ready, 0);
    check("R1 msg_ready cleared", msg_ready, 0);
    pop(1, 0, "R1 cmp pop after reset");
    do_setup(0, 1, 1, 0, "R1 setup after reset");
    req_prod = 2;
    pop(0, 0, "R1 page table cleared slot0");
    pop(0, 128, "R1 page table cleared slot1");
  endtask

  initial begin
    #4000000;
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1;
    step();
    t_reset();
    t_bad_setup();
    t_setup();
    t_req_pops();
    t_req_wrap();
    t_cmp();
    t_msg_setup();
    t_msg_room();
    t_flush_all();
    t_pop_priority();
    t_reset_mid();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule